// File: doc/BRIEF.md
# Single-Line Bit-Serial Memory Target

This block is the device side of a small nonvolatile byte memory that hangs on an ordinary processor bus and moves every command, address and data bit over a single data line. The host talks to it with plain bus cycles. A write cycle has chip-enable and write-enable low with output-enable high, and it carries one bit in. A read cycle has chip-enable and output-enable low with write-enable high, and it returns one bit. Short patterns of read and write cycles act as commands. One pattern clears the protocol and arms the write latch. Another starts a nonvolatile commit of the loaded page.

All bus strobes are sampled on a system clock. A bus cycle counts as finished on the first clock where its strobe pair is no longer asserted, and the bit taken is the one held on the data line during the last asserted clock. The storage is a register array. A 32-byte page buffer collects write data, and the commit copies the loaded bytes into the array one byte per clock while the block reports busy for a programmable number of clocks.

Top module: `bsm_target`

## Requirements
- R1: A write cycle (ce_n=0, we_n=0, oe_n=1) delivers the value that dq_in held in its last asserted clock. A read cycle (ce_n=0, oe_n=0, we_n=1) ends when that pair deasserts. dq_oe is 1 exactly while ce_n and oe_n are both 0.
- R2: A read cycle followed directly by a write of 0 is a reset. It abandons any sequence, sets the write-enable latch when wp_n is 1, and empties the page buffer. A read issued right after the reset is absorbed. Every read returns 1 until 16 address bits have been written.
- R3: The address is 16 write cycles, most significant bit first. Only the low log2(DEPTH) bits select a byte, so 0xF840 and 0x0040 name the same byte.
- R4: Once the address is complete, successive reads return the addressed byte from bit 7 down to bit 0. After each 8th read the pointer advances, and it wraps from DEPTH-1 to 0.
- R5: A write of 1 during reading sends the block to idle, and later reads return 1.
- R6: Write cycles after the address load bytes, most significant bit first, into the page at offset = address bits 4..0. The offset increments after each byte and wraps from 31 to 0 inside the 32-byte page, so a later byte replaces an earlier one.
- R7: Read, write 1, read after a page load starts a commit when the latch is set, at least one full byte is loaded and no partial byte is pending. Only the loaded page bytes change.
- R8: A commit attempted with a partial byte pending writes nothing. The block goes idle with the latch cleared.
- R9: While a commit runs, every read returns 0 and every pattern, reset included, is ignored. After COMMIT_CYCLES clocks reads return 1 and the latch is clear.
- R10: While wp_n is 0 the latch is held clear, so a commit attempt does nothing. wp_n falling during a running commit does not stop it.
- R11: Read then write 1 (in idle, during address load, during reading), read-read-write 1 after a load, and read-write 1-write all send the block to idle and clear the latch. In idle, reads return 1 and writes store nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low reset, latch and protocol cleared |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| wp_n | input | 1 | Active-low write protect |
| dq_in | input | 1 | Serial data line, host to block |
| dq_out | output | 1 | Serial data line, block to host |
| dq_oe | output | 1 | Drive enable for dq_out |

## Verification
The hardest states to reach are the two edges of a running commit: a reset pattern or a write-protect fall arriving in the middle of it, and the last busy clock before the status line turns to 1. The bench reaches them by issuing a commit and then, with no gap, either a full reset pattern or a drop of wp_n, followed by polling reads. Its model counts down the busy window clock by clock, so every polled bit, including the read that straddles the end of the window, is compared with the expected value. Page-wrap overwrite and a read pointer that wraps across the top of the array are set up by placing single bytes at offset 31 and at address 0 before reading across them.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_IDLE_R,
        ST_ADDR,
        ST_ADDR_R,
        ST_AREADY,
        ST_READ,
        ST_LOAD,
        ST_CM1,
        ST_CM2,
        ST_CMRR,
        ST_BUSY
    } bsm_state_e;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_READ,
        EV_WR0,
        EV_WR1
    } bsm_event_e;

    typedef struct packed {
        logic wr;
        logic rd;
        logic bit_v;
    } bsm_bus_t;

    typedef struct packed {
        logic       v;
        logic [7:0] d;
    } bsm_lane_t;

endpackage

// File: rtl/bsm_bus_sample.sv
module bsm_bus_sample
    import bsm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       oe_n,
    input  logic       we_n,
    input  logic       dq_in,
    output bsm_event_e ev,
    output logic       rd_active
);

    bsm_bus_t bus_d, bus_q;
    logic     wr_now, rd_now;

    always_comb begin
        wr_now      = !ce_n && !we_n && oe_n;
        rd_now      = !ce_n && !oe_n && we_n;
        bus_d.wr    = wr_now;
        bus_d.rd    = rd_now;
        bus_d.bit_v = wr_now ? dq_in : bus_q.bit_v;
        if (bus_q.wr && !wr_now)
            ev = bus_q.bit_v ? EV_WR1 : EV_WR0;
        else if (bus_q.rd && !rd_now)
            ev = EV_READ;
        else
            ev = EV_NONE;
        rd_active = !ce_n && !oe_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_q <= '0;
        else        bus_q <= bus_d;
    end

endmodule

// File: rtl/bsm_page_buf.sv
module bsm_page_buf
    import bsm_pkg::*;
#(
    parameter int PAGE_BYTES = 32,
    parameter int OW         = $clog2(PAGE_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          we,
    input  logic [OW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [OW-1:0] raddr,
    output logic [7:0]    rdata,
    output logic          rvalid
);

    logic [7:0] lane_dat [PAGE_BYTES];
    logic       lane_vld [PAGE_BYTES];

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_lane
        bsm_lane_t ln_d, ln_q;

        always_comb begin
            ln_d = ln_q;
            if (clear) begin
                ln_d.v = 1'b0;
            end else if (we && waddr == OW'(i)) begin
                ln_d.v = 1'b1;
                ln_d.d = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ln_q <= '0;
            else        ln_q <= ln_d;
        end

        assign lane_dat[i] = ln_q.d;
        assign lane_vld[i] = ln_q.v;
    end

    assign rdata  = lane_dat[raddr];
    assign rvalid = lane_vld[raddr];

endmodule

// File: rtl/bsm_array.sv
module bsm_array #(
    parameter int DEPTH = 2048,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/bsm_target.sv
module bsm_target
    import bsm_pkg::*;
#(
    parameter int ADDR_BITS     = 16,
    parameter int DEPTH         = 2048,
    parameter int PAGE_BYTES    = 32,
    parameter int COMMIT_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic wp_n,
    input  logic dq_in,
    output logic dq_out,
    output logic dq_oe
);

    localparam int AW  = $clog2(DEPTH);
    localparam int OW  = $clog2(PAGE_BYTES);
    localparam int PW  = AW - OW;
    localparam int ACW = $clog2(ADDR_BITS + 1);
    localparam int CW  = $clog2(COMMIT_CYCLES + 1);

    typedef struct packed {
        bsm_state_e     st;
        logic           wel;
        logic [AW-1:0]  ptr;
        logic [ACW-1:0] acnt;
        logic [2:0]     bitn;
        logic [7:0]     shreg;
        logic [OW-1:0]  off;
        logic           any;
        logic [CW-1:0]  busy;
        logic [OW:0]    cidx;
    } core_t;

    core_t      state_d, state_q;
    bsm_event_e ev;
    logic       rd_active;

    logic          pb_clear, pb_we, pb_rvalid;
    logic [7:0]    pb_wdata, pb_rdata;
    logic          arr_we;
    logic [AW-1:0] arr_waddr;
    logic [7:0]    arr_rdata;

    logic is_wr, wbit;
    logic do_reset, do_illegal, do_adv, do_load;

    bsm_bus_sample u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .dq_in     (dq_in),
        .ev        (ev),
        .rd_active (rd_active)
    );

    bsm_page_buf #(
        .PAGE_BYTES (PAGE_BYTES),
        .OW         (OW)
    ) u_page (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (pb_clear),
        .we     (pb_we),
        .waddr  (state_q.off),
        .wdata  (pb_wdata),
        .raddr  (state_q.cidx[OW-1:0]),
        .rdata  (pb_rdata),
        .rvalid (pb_rvalid)
    );

    bsm_array #(
        .DEPTH (DEPTH),
        .AW    (AW)
    ) u_array (
        .clk   (clk),
        .we    (arr_we),
        .waddr (arr_waddr),
        .wdata (pb_rdata),
        .raddr (state_q.ptr),
        .rdata (arr_rdata)
    );

    always_comb begin
        state_d    = state_q;
        is_wr      = (ev == EV_WR0) || (ev == EV_WR1);
        wbit       = (ev == EV_WR1);
        do_reset   = 1'b0;
        do_illegal = 1'b0;
        do_adv     = 1'b0;
        do_load    = 1'b0;
        pb_clear   = 1'b0;
        pb_we      = 1'b0;
        pb_wdata   = {state_q.shreg[6:0], wbit};
        arr_we     = 1'b0;
        arr_waddr  = {state_q.ptr[AW-1:OW], state_q.cidx[OW-1:0]};

        unique case (state_q.st)
            ST_IDLE: begin
                if (ev == EV_READ) state_d.st = ST_IDLE_R;
            end
            ST_IDLE_R, ST_ADDR_R, ST_READ, ST_CMRR: begin
                if (ev == EV_WR0)      do_reset   = 1'b1;
                else if (ev == EV_WR1) do_illegal = 1'b1;
                else if (ev == EV_READ && state_q.st == ST_READ) do_adv = 1'b1;
            end
            ST_ADDR: begin
                if (is_wr) begin
                    state_d.ptr  = {state_q.ptr[AW-2:0], wbit};
                    state_d.acnt = state_q.acnt + 1'b1;
                    if (state_q.acnt == ACW'(ADDR_BITS - 1)) begin
                        state_d.st   = ST_AREADY;
                        state_d.off  = state_d.ptr[OW-1:0];
                        state_d.bitn = 3'd0;
                    end
                end else if (ev == EV_READ && state_q.acnt != '0) begin
                    state_d.st = ST_ADDR_R;
                end
            end
            ST_AREADY: begin
                if (ev == EV_READ) begin
                    state_d.st = ST_READ;
                    do_adv     = 1'b1;
                end else if (is_wr) begin
                    state_d.st = ST_LOAD;
                    do_load    = 1'b1;
                end
            end
            ST_LOAD: begin
                if (is_wr)              do_load    = 1'b1;
                else if (ev == EV_READ) state_d.st = ST_CM1;
            end
            ST_CM1: begin
                if (ev == EV_READ)     state_d.st = ST_CMRR;
                else if (ev == EV_WR1) state_d.st = ST_CM2;
                else if (ev == EV_WR0) do_reset   = 1'b1;
            end
            ST_CM2: begin
                if (is_wr) begin
                    do_illegal = 1'b1;
                end else if (ev == EV_READ) begin
                    if (state_q.wel && state_q.any && state_q.bitn == 3'd0) begin
                        state_d.st   = ST_BUSY;
                        state_d.busy = CW'(COMMIT_CYCLES - 1);
                        state_d.cidx = '0;
                    end else begin
                        do_illegal = 1'b1;
                    end
                end
            end
            ST_BUSY: begin
                if (state_q.cidx < (OW+1)'(PAGE_BYTES)) begin
                    arr_we       = pb_rvalid;
                    state_d.cidx = state_q.cidx + 1'b1;
                end
                if (state_q.busy == '0) begin
                    state_d.st  = ST_IDLE;
                    state_d.wel = 1'b0;
                    pb_clear    = 1'b1;
                end else begin
                    state_d.busy = state_q.busy - 1'b1;
                end
            end
            default: state_d.st = ST_IDLE;
        endcase

        if (do_adv) begin
            if (state_q.bitn == 3'd7) begin
                state_d.bitn = 3'd0;
                state_d.ptr  = state_q.ptr + 1'b1;
            end else begin
                state_d.bitn = state_q.bitn + 1'b1;
            end
        end

        if (do_load) begin
            state_d.shreg = pb_wdata;
            if (state_q.bitn == 3'd7) begin
                pb_we        = 1'b1;
                state_d.off  = state_q.off + 1'b1;
                state_d.any  = 1'b1;
                state_d.bitn = 3'd0;
            end else begin
                state_d.bitn = state_q.bitn + 1'b1;
            end
        end

        if (do_reset) begin
            state_d.st   = ST_ADDR;
            state_d.acnt = '0;
            state_d.wel  = 1'b1;
            state_d.bitn = 3'd0;
            state_d.any  = 1'b0;
            pb_clear     = 1'b1;
        end

        if (do_illegal) begin
            state_d.st  = ST_IDLE;
            state_d.wel = 1'b0;
        end

        if (!wp_n) state_d.wel = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= '0;
            state_q.st <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        dq_oe = rd_active;
        if (state_q.st == ST_BUSY)
            dq_out = 1'b0;
        else if (state_q.st == ST_AREADY || state_q.st == ST_READ)
            dq_out = arr_rdata[3'd7 - state_q.bitn];
        else
            dq_out = 1'b1;
    end

endmodule

// File: rtl/bsm_target_chk.sv
module bsm_target_chk
    import bsm_pkg::*;
#(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wp_n,
    input logic          dq_oe,
    input logic          dq_out,
    input bsm_event_e    ev,
    input bsm_state_e    st,
    input logic          wel,
    input logic [CW-1:0] busy
);

    p_busy_reads_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BUSY && dq_oe) |-> !dq_out);

    p_busy_ends_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BUSY && busy == '0) |=> (st == ST_IDLE && !wel));

    p_reset_reads_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ADDR && dq_oe) |-> dq_out);

    p_wp_clears_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_n |=> !wel);

    p_busy_not_aborted_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BUSY && busy != '0) |=> st == ST_BUSY);

    p_commit_needs_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st == ST_BUSY) |-> $past(wel));

    p_rww_to_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CM2 && (ev == EV_WR0 || ev == EV_WR1)) |=> (st == ST_IDLE && !wel));

    p_read_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READ && ev == EV_WR1) |=> st == ST_IDLE);

endmodule

bind bsm_target bsm_target_chk #(
    .CW ($clog2(COMMIT_CYCLES + 1))
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wp_n   (wp_n),
    .dq_oe  (dq_oe),
    .dq_out (dq_out),
    .ev     (ev),
    .st     (state_q.st),
    .wel    (state_q.wel),
    .busy   (state_q.busy)
);

// File: tb/bsm_target_test.sv
module bsm_target_test;

    localparam int DEPTH = 2048;
    localparam int CYC   = 200;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, wp_n = 1'b1, dq_in = 1'b0;
    logic dq_out, dq_oe;

    bsm_target #(.DEPTH(DEPTH), .COMMIT_CYCLES(CYC)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .wp_n(wp_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always #10 clk = ~clk;

    int    checks = 0, errors = 0;
    string tag = "R1";
    logic  last_rd;

    // behavioural reference
    localparam int M_IDLE = 0, M_IDLE_R = 1, M_ADDR = 2, M_ADDR_R = 3, M_READY = 4,
                   M_READING = 5, M_LOAD = 6, M_AFTER_R = 7, M_AFTER_RW1 = 8, M_AFTER_RR = 9;
    int         md = M_IDLE;
    bit         m_wel = 0, m_any = 0;
    int         m_busy = 0, m_acc = 0, m_na = 0, m_ptr = 0, m_off = 0, m_bit = 0, m_ld = 0;
    int         pbuf [32];
    logic [7:0] mem_m [DEPTH];

    task automatic check(string t, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", t, act, exp, $time);
        end
    endtask

    function automatic logic m_expect();
        if (m_busy > 0) return 1'b0;
        if (md == M_READY || md == M_READING) return mem_m[m_ptr][7 - m_bit];
        return 1'b1;
    endfunction

    task automatic m_arm();
        md = M_ADDR; m_na = 0; m_acc = 0; m_wel = wp_n; m_bit = 0; m_any = 0;
        foreach (pbuf[i]) pbuf[i] = -1;
    endtask

    task automatic m_bad();
        md = M_IDLE; m_wel = 0;
    endtask

    task automatic m_adv();
        if (m_bit == 7) begin m_bit = 0; m_ptr = (m_ptr + 1) % DEPTH; end
        else m_bit++;
    endtask

    task automatic m_loadbit(bit b);
        m_ld = ((m_ld << 1) | b) & 255;
        if (m_bit == 7) begin
            pbuf[m_off] = m_ld; m_off = (m_off + 1) % 32; m_any = 1; m_bit = 0;
        end else m_bit++;
    endtask

    task automatic model_event(int k);
        bit w = (k != 0);
        bit b = (k == 2);
        if (m_busy > 0) return;
        case (md)
            M_IDLE:   if (!w) md = M_IDLE_R;
            M_IDLE_R, M_ADDR_R, M_AFTER_RR:
                if (w) begin if (b) m_bad(); else m_arm(); end
            M_READING:
                if (w) begin if (b) m_bad(); else m_arm(); end else m_adv();
            M_ADDR:
                if (w) begin
                    m_acc = ((m_acc << 1) | b) & 16'hFFFF; m_na++;
                    if (m_na == 16) begin
                        m_ptr = m_acc % DEPTH; m_off = m_acc % 32; m_bit = 0; md = M_READY;
                    end
                end else if (m_na != 0) md = M_ADDR_R;
            M_READY:
                if (!w) begin md = M_READING; m_adv(); end
                else begin md = M_LOAD; m_loadbit(b); end
            M_LOAD:   if (w) m_loadbit(b); else md = M_AFTER_R;
            M_AFTER_R:
                if (!w) md = M_AFTER_RR;
                else if (b) md = M_AFTER_RW1;
                else m_arm();
            M_AFTER_RW1:
                if (w) m_bad();
                else if (m_wel && m_any && m_bit == 0) begin
                    for (int i = 0; i < 32; i++)
                        if (pbuf[i] >= 0) mem_m[(m_ptr & ~31) | i] = pbuf[i][7:0];
                    m_busy = CYC; md = M_IDLE; m_wel = 0;
                end else m_bad();
            default: md = M_IDLE;
        endcase
    endtask

    // per-clock comparison against the reference
    always @(posedge clk) begin
        #5;
        if (m_busy > 0) m_busy--;
        if (!wp_n) m_wel = 0;
        if (rst_n) begin
            check("R1 dq_oe", dq_oe, !ce_n && !oe_n);
            if (!ce_n && !oe_n) check({tag, " per-clock dq"}, dq_out, m_expect());
        end
    end

    task automatic wr(bit b);
        @(negedge clk); ce_n = 0; we_n = 0; oe_n = 1; dq_in = b;
        @(negedge clk);
        @(negedge clk); ce_n = 1; we_n = 1;
        @(negedge clk); model_event(b ? 2 : 1);
    endtask

    task automatic rd();
        logic e;
        @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1;
        @(negedge clk);
        @(negedge clk);
        e = m_expect();
        last_rd = dq_out;
        check(tag, dq_out, e);
        ce_n = 1; oe_n = 1;
        @(negedge clk); model_event(0);
    endtask

    task automatic do_reset(); rd(); wr(0); rd(); endtask
    task automatic send_addr(int a); for (int i = 15; i >= 0; i--) wr(a[i]); endtask
    task automatic load_byte(int v); for (int i = 7; i >= 0; i--) wr(v[i]); endtask
    task automatic read_bytes(int n); for (int i = 0; i < n * 8; i++) rd(); endtask
    task automatic commit(); rd(); wr(1); rd(); endtask
    task automatic wait_ready();
        for (int i = 0; i < 400; i++) begin
            rd();
            if (last_rd === 1'b1) break;
        end
    endtask

    initial begin
        #(20 * 150000);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        foreach (pbuf[i]) pbuf[i] = -1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        tag = "R1"; check("R1 reset dq_oe", dq_oe, 1'b0);
        tag = "R11"; rd();                       // idle read returns 1

        // R6 R7 R9: load four bytes at 0x0040 and commit
        tag = "R2"; do_reset(); rd();
        tag = "R6"; send_addr(16'h0040);
        load_byte(8'hA1); load_byte(8'hB2); load_byte(8'hC3); load_byte(8'hD4);
        tag = "R7"; commit();
        tag = "R9"; wait_ready();
        tag = "R4"; do_reset(); send_addr(16'h0040); read_bytes(4);
        tag = "R5"; wr(1); rd(); rd();

        // R6 page wrap: start at offset 30 of page 0x60
        tag = "R6"; do_reset(); send_addr(16'h007E);
        load_byte(8'h11); load_byte(8'h22); load_byte(8'h33); load_byte(8'h44);
        commit(); wait_ready();
        do_reset(); send_addr(16'h0060); read_bytes(2);
        do_reset(); send_addr(16'h007E); read_bytes(2);

        // R6 overwrite: 33 bytes into page 0x100
        do_reset(); send_addr(16'h0100);
        for (int i = 0; i < 33; i++) load_byte(i * 7 + 3);
        commit(); wait_ready();
        do_reset(); send_addr(16'h0100); read_bytes(2);

        // R3 high address bits ignored
        tag = "R3"; do_reset(); send_addr(16'hF840); read_bytes(1);

        // R4 pointer wrap at top of array
        tag = "R4"; do_reset(); send_addr(16'h07FF); load_byte(8'h5A); commit(); wait_ready();
        do_reset(); send_addr(16'h0000); load_byte(8'h3C); commit(); wait_ready();
        do_reset(); send_addr(16'h07FF); read_bytes(2);

        // R8 partial byte then commit pattern
        tag = "R8"; do_reset(); send_addr(16'h0040);
        for (int i = 0; i < 12; i++) wr(0);
        commit(); rd();
        do_reset(); send_addr(16'h0040); read_bytes(1);

        // R10 protect low blocks the commit
        tag = "R10"; wp_n = 0; do_reset(); send_addr(16'h0041); load_byte(8'h99);
        commit(); rd();
        wp_n = 1; do_reset(); send_addr(16'h0041); read_bytes(1);

        // R10 protect falling during busy does not abort
        do_reset(); send_addr(16'h0042); load_byte(8'h77); commit();
        @(negedge clk); wp_n = 0;
        wait_ready(); wp_n = 1;
        do_reset(); send_addr(16'h0042); read_bytes(1);

        // R9 reset during busy keeps status low
        tag = "R9"; do_reset(); send_addr(16'h0043); load_byte(8'h66); commit();
        do_reset(); wait_ready();
        do_reset(); send_addr(16'h0043); read_bytes(1);

        // R11 read/write1 during address load
        tag = "R11"; do_reset(); send_addr(16'h0000);
        do_reset(); for (int i = 0; i < 8; i++) wr(0);
        rd(); wr(1); for (int i = 0; i < 8; i++) wr(0); rd(); rd();

        // R11 read/read/write1 after load
        do_reset(); send_addr(16'h0040); load_byte(8'hEE);
        rd(); rd(); wr(1); rd(); wr(1); rd();
        do_reset(); send_addr(16'h0040); read_bytes(1);

        // R11 read/write1/write after load
        do_reset(); send_addr(16'h0040); load_byte(8'hEE);
        rd(); wr(1); wr(0); rd();
        do_reset(); send_addr(16'h0040); read_bytes(1);

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule